// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the register file and start controller for a 128-bit block-cipher engine. A simple single-cycle bus (select, write strobe, byte address, 32-bit data) reaches a mode word, an interrupt mask and a status word. It also reaches four-word banks for the key, the input block, the output block and the initialization vector. The engine sits behind a handshake. The block drives `core_start` for one cycle. The engine answers with `core_busy` while it works, marks sub-key generation with `core_keygen`, and pulses `core_done` when the result on `core_dout` is valid. The engine must capture `core_din` on the start pulse.

Starts come from one of three policies: an explicit control write, completion of all four input words, or a write to input word 0 alone. In the last policy an optional double-buffer setting lets the next block be loaded while the current one is still being processed. That start is then held pending until the engine goes idle. Accesses that are illegal in the engine's present phase are blocked and reported through a sticky flag with a type code. The countermeasure enables in the mode word can only be changed by a write that carries a 4-bit key.

Top module: `crypt_regfront`

## Requirements
- R1: After reset, and after a control write (0x00) with bit 8 set, the mode, mask, status, key, input and IV registers read or drive zero. A start that was pending is dropped and never issued.
- R2: The mode word (0x04) keeps bit 0, bit 3 (double buffer), bits 7:4, bits 9:8 (start policy) and bits 14:12 as written. All other bits read zero, including the key field at bits 23:20.
- R3: Mode bits 29:24 take the written value only when the same write carries 0xE in bits 23:20. With any other key they keep their old value.
- R4: A write to 0x10 sets, and a write to 0x14 clears, the mask bit for data-ready (data bit 0) and for the access flag (data bit 8). 0x18 reads the mask at those positions. `irq` is high while any status bit is set together with its mask bit.
- R5: A control write with bit 0 set, with the engine idle, drives `core_start` high for exactly one cycle, starting in the cycle after the write. In start policy 0, writing input words starts nothing.
- R6: In start policy 1, a start is issued once all four input words (0x40, 0x44, 0x48, 0x4C) have been written since the previous start. Rewriting some words only does not start.
- R7: In start policy 2, a write to input word 0 (0x40) starts, and other input words do not. If the engine is busy, the start is held until `core_busy` falls.
- R8: Input writes while `core_busy` is high are dropped, unless start policy is 2 and double buffer is set. In policy 2 without double buffer, such a write sets the access flag with code 0. In the other policies the write is dropped without a flag.
- R9: Data-ready (status bit 0) is set by `core_done`. It clears on a legal output-word read or on a start.
- R10: While the engine is in processing (busy, not keygen), an output read returns zero with code 1 and a mode write is ignored with code 2. During sub-key generation the same accesses give code 3 and code 4.
- R11: Reading a write-only location (0x00, 0x10, 0x14, key, input or IV words) returns zero and sets the access flag with code 5.
- R12: Status (0x1C) shows the access flag at bit 8 and its code at bits 15:12. Reading status clears both. While the flag is set, later violations do not replace the code.
- R13: Word i of each bank sits at bank base + 4*i and maps to bits 32*i+31 down to 32*i of the matching 128-bit port. 0x FC reads the 12-bit version parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Masked interrupt |
| core_start | output | 1 | One-cycle start to the engine |
| core_busy | input | 1 | Engine working |
| core_keygen | input | 1 | Engine is generating sub-keys (with busy) |
| core_done | input | 1 | Result valid pulse |
| core_dout | input | 128 | Engine result block |
| core_key | output | 128 | Key register |
| core_din | output | 128 | Input block register |
| core_iv | output | 128 | Initialization vector register |
| core_mode | output | 32 | Mode word as read back |

## Verification
Read data is combinational and is sampled in the same cycle as the access. Every register effect, including the status code, mask, data-ready, `irq` and the dropping or acceptance of an input word, shows up after the clock edge that ends the access. The bench therefore checks these one cycle later, at the falling edge. `core_start` rises in the cycle after the triggering write and is checked at that falling edge. Its single-cycle width is checked at the next one. A start that is held pending is counted only after the edge that follows the fall of `core_busy`.

// File: rtl/crypt_regfront.sv
module crypt_regfront #(
  parameter logic [11:0] HW_VERSION = 12'h1A5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         irq,
  output logic         core_start,
  input  logic         core_busy,
  input  logic         core_keygen,
  input  logic         core_done,
  input  logic [127:0] core_dout,
  output logic [127:0] core_key,
  output logic [127:0] core_din,
  output logic [127:0] core_iv,
  output logic [31:0]  core_mode
);
  localparam logic [31:0] MODE_MASK = 32'h0000_73F9;
  localparam logic [31:0] CM_MASK   = 32'h3F00_0000;
  localparam logic [3:0]  CM_KEY    = 4'hE;

  logic [127:0] key_q, din_q, iv_q;
  logic [31:0]  mode_q;
  logic [1:0]   imr_q;
  logic         datrdy_q, urad_q, pend_q;
  logic [3:0]   urat_q, seen_q;

  logic wr, rd, soft_rst, in_proc, in_kgen, in_ok, in_wr, trig, viol, word_ok;
  logic hit_ctrl, hit_mode, hit_ier, hit_idr, hit_imr, hit_isr, hit_ver;
  logic hit_key, hit_in, hit_out, hit_iv;
  logic [1:0] smod, widx;
  logic       dualbuf;
  logic [3:0] code, seen_nx;

  assign wr       = bus_sel & bus_wr;
  assign rd       = bus_sel & ~bus_wr;
  assign widx     = bus_addr[3:2];
  assign word_ok  = bus_addr[1:0] == 2'd0;
  assign hit_ctrl = bus_addr == 8'h00;
  assign hit_mode = bus_addr == 8'h04;
  assign hit_ier  = bus_addr == 8'h10;
  assign hit_idr  = bus_addr == 8'h14;
  assign hit_imr  = bus_addr == 8'h18;
  assign hit_isr  = bus_addr == 8'h1C;
  assign hit_ver  = bus_addr == 8'hFC;
  assign hit_key  = bus_addr[7:4] == 4'h2 && word_ok;
  assign hit_in   = bus_addr[7:4] == 4'h4 && word_ok;
  assign hit_out  = bus_addr[7:4] == 4'h5 && word_ok;
  assign hit_iv   = bus_addr[7:4] == 4'h6 && word_ok;

  assign soft_rst = wr & hit_ctrl & bus_wdata[8];
  assign smod     = mode_q[9:8];
  assign dualbuf  = mode_q[3];
  assign in_proc  = core_busy & ~core_keygen;
  assign in_kgen  = core_busy & core_keygen;
  assign in_ok    = ~core_busy | (smod == 2'd2 & dualbuf);
  assign in_wr    = wr & hit_in & in_ok;
  assign seen_nx  = seen_q | (4'b0001 << widx);

  assign trig = (wr & hit_ctrl & bus_wdata[0])
              | (in_wr & smod == 2'd1 & seen_nx == 4'hF)
              | (in_wr & smod == 2'd2 & widx == 2'd0);

  assign core_start = pend_q & ~core_busy;
  assign core_key   = key_q;
  assign core_din   = din_q;
  assign core_iv    = iv_q;
  assign core_mode  = mode_q;
  assign irq        = (datrdy_q & imr_q[0]) | (urad_q & imr_q[1]);

  always_comb begin
    viol = 1'b1;
    code = 4'd0;
    if (wr & hit_in & in_proc & smod == 2'd2 & ~dualbuf) code = 4'd0;
    else if (rd & hit_out & in_proc)                     code = 4'd1;
    else if (wr & hit_mode & in_proc)                    code = 4'd2;
    else if (rd & hit_out & in_kgen)                     code = 4'd3;
    else if (wr & hit_mode & in_kgen)                    code = 4'd4;
    else if (rd & (hit_ctrl | hit_ier | hit_idr | hit_key | hit_in | hit_iv))
                                                         code = 4'd5;
    else viol = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      iv_q  <= '0;
      din_q <= '0;
    end else if (soft_rst) begin
      key_q <= '0;
      iv_q  <= '0;
      din_q <= '0;
    end else begin
      if (wr & hit_key) key_q[32*widx +: 32] <= bus_wdata;
      if (wr & hit_iv)  iv_q[32*widx +: 32]  <= bus_wdata;
      if (in_wr)        din_q[32*widx +: 32] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      imr_q  <= '0;
    end else if (soft_rst) begin
      mode_q <= '0;
      imr_q  <= '0;
    end else begin
      if (wr & hit_mode & ~core_busy)
        mode_q <= (bus_wdata & MODE_MASK) |
                  ((bus_wdata[23:20] == CM_KEY) ? (bus_wdata & CM_MASK) : (mode_q & CM_MASK));
      if (wr & hit_ier) imr_q <= imr_q | {bus_wdata[8], bus_wdata[0]};
      else if (wr & hit_idr) imr_q <= imr_q & ~{bus_wdata[8], bus_wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= '0;
    end else if (soft_rst) begin
      pend_q <= 1'b0;
      seen_q <= '0;
    end else begin
      pend_q <= trig | (pend_q & ~core_start);
      if (in_wr & smod == 2'd1) seen_q <= (seen_nx == 4'hF) ? 4'h0 : seen_nx;
      else if (core_start)      seen_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      datrdy_q <= 1'b0;
      urad_q   <= 1'b0;
      urat_q   <= '0;
    end else if (soft_rst) begin
      datrdy_q <= 1'b0;
      urad_q   <= 1'b0;
      urat_q   <= '0;
    end else begin
      if (core_done) datrdy_q <= 1'b1;
      else if (core_start | (rd & hit_out & ~core_busy)) datrdy_q <= 1'b0;
      if (viol & ~urad_q) begin
        urad_q <= 1'b1;
        urat_q <= code;
      end else if (rd & hit_isr) begin
        urad_q <= 1'b0;
        urat_q <= '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mode)     bus_rdata = mode_q;
    else if (hit_imr) bus_rdata = {23'd0, imr_q[1], 7'd0, imr_q[0]};
    else if (hit_isr) bus_rdata = {16'd0, urat_q, 3'd0, urad_q, 7'd0, datrdy_q};
    else if (hit_ver) bus_rdata = {20'd0, HW_VERSION};
    else if (hit_out & ~core_busy) bus_rdata = core_dout[32*widx +: 32];
  end
endmodule

// File: rtl/crypt_regfront_chk.sv
module crypt_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        core_busy,
  input logic        core_done,
  input logic        core_start,
  input logic [31:0] core_mode,
  input logic        datrdy_q,
  input logic        urad_q,
  input logic [3:0]  urat_q
);
  logic swr, mwr, srd;
  assign swr = bus_sel & bus_wr & bus_addr == 8'h00 & bus_wdata[8];
  assign mwr = bus_sel & bus_wr & bus_addr == 8'h04;
  assign srd = bus_sel & ~bus_wr & bus_addr == 8'h1C;

  assert_swrst_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (core_mode == 32'd0 && !core_start && !datrdy_q && !urad_q));

  assert_key_field_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_mode[23:20] == 4'd0);

  assert_cm_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr && bus_wdata[23:20] != 4'hE) |=> $stable(core_mode[29:24]));

  assert_busy_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr && core_busy) |=> $stable(core_mode));

  assert_done_sets_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !swr) |=> datrdy_q);

  assert_first_code_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (urad_q && !srd && !swr) |=> (urad_q && $stable(urat_q)));
endmodule

bind crypt_regfront crypt_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .core_busy(core_busy),
  .core_done(core_done), .core_start(core_start), .core_mode(core_mode),
  .datrdy_q(datrdy_q), .urad_q(urad_q), .urat_q(urat_q)
);

// File: tb/crypt_regfront_tb.sv
`timescale 1ns/1ps
module crypt_regfront_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, core_start;
  logic core_busy = 1'b0, core_keygen = 1'b0, core_done = 1'b0;
  logic [127:0] core_dout = '0, core_key, core_din, core_iv;
  logic [31:0] core_mode;
  int n_chk = 0, n_bad = 0, n_start = 0;

  always #5 clk = ~clk;

  crypt_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .core_start(core_start), .core_busy(core_busy),
    .core_keygen(core_keygen), .core_done(core_done), .core_dout(core_dout),
    .core_key(core_key), .core_din(core_din), .core_iv(core_iv),
    .core_mode(core_mode)
  );

  always @(posedge clk) if (rst_n && core_start) n_start <= n_start + 1;

  // {write, check, addr, wdata, expected read}
  localparam logic [73:0] VEC [22] = '{
    {1'b0, 1'b1, 8'h04, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h18, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h1C, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'hFC, 32'h0, 32'h0000_01A5},
    {1'b1, 1'b0, 8'h04, 32'h3FE0_73F9, 32'h0},
    {1'b0, 1'b1, 8'h04, 32'h0, 32'h3F00_73F9},
    {1'b1, 1'b0, 8'h04, 32'h0050_0001, 32'h0},
    {1'b0, 1'b1, 8'h04, 32'h0, 32'h3F00_0001},
    {1'b1, 1'b0, 8'h04, 32'h00E0_0000, 32'h0},
    {1'b0, 1'b1, 8'h04, 32'h0, 32'h0},
    {1'b1, 1'b0, 8'h10, 32'h0000_0101, 32'h0},
    {1'b0, 1'b1, 8'h18, 32'h0, 32'h0000_0101},
    {1'b1, 1'b0, 8'h14, 32'h0000_0001, 32'h0},
    {1'b0, 1'b1, 8'h18, 32'h0, 32'h0000_0100},
    {1'b0, 1'b1, 8'h20, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h1C, 32'h0, 32'h0000_5100},
    {1'b0, 1'b1, 8'h1C, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h00, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h64, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h1C, 32'h0, 32'h0000_5100},
    {1'b1, 1'b0, 8'h10, 32'h0000_0001, 32'h0},
    {1'b0, 1'b1, 8'h18, 32'h0, 32'h0000_0101}
  };

  task automatic expect32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #2 r = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1'b1, a, d, r);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] r;
    access(1'b0, a, 32'h0, r);
    expect32(tag, r, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_busy = 1'b0; core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect32("R1 reset din", core_din[31:0], 32'h0);

    // table: R1 R2 R3 R4 R11 R12 R13
    for (int i = 0; i < 22; i++) begin
      access(VEC[i][73], VEC[i][71:64], VEC[i][63:32], r);
      if (VEC[i][72]) expect32($sformatf("R2/R3/R4/R11/R12 vector %0d", i), r, VEC[i][31:0]);
    end

    // manual start, policy 0
    for (int i = 0; i < 4; i++) begin
      wr32(8'h20 + 8'(4*i), 32'hC0DE_0000 + i);
      wr32(8'h60 + 8'(4*i), 32'h1F00_0000 + i);
      wr32(8'h40 + 8'(4*i), 32'hA0A0_0000 + i);
    end
    expect32("R13 din word3", core_din[127:96], 32'hA0A0_0003);
    expect32("R13 key word1", core_key[63:32], 32'hC0DE_0001);
    expect32("R13 iv word2",  core_iv[95:64],  32'h1F00_0002);
    expect32("R5 no auto start in policy 0", n_start, 0);
    wr32(8'h00, 32'h1);
    expect32("R5 start pulse", {31'd0, core_start}, 32'd1);
    @(negedge clk);
    expect32("R5 start width", {31'd0, core_start}, 32'd0);
    expect32("R5 start count", n_start, 1);

    core_busy = 1'b1; core_keygen = 1'b1;
    rd_chk("R10 out read in keygen", 8'h50, 32'h0);
    wr32(8'h04, 32'h8);
    rd_chk("R10 mode write in keygen ignored", 8'h04, 32'h0);
    rd_chk("R12 first code kept (3)", 8'h1C, 32'h0000_3100);
    rd_chk("R12 status cleared", 8'h1C, 32'h0);
    @(negedge clk); core_keygen = 1'b0;
    rd_chk("R10 out read in processing", 8'h54, 32'h0);
    wr32(8'h04, 32'h8);
    rd_chk("R10 code 1 then 2 keeps 1", 8'h1C, 32'h0000_1100);
    wr32(8'h44, 32'hDEAD_BEEF);
    expect32("R8 busy input write dropped", core_din[63:32], 32'hA0A0_0001);
    rd_chk("R8 no flag in policy 0", 8'h1C, 32'h0);

    core_dout = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    pulse_done();
    expect32("R4 irq on data-ready", {31'd0, irq}, 32'd1);
    rd_chk("R9 data-ready set", 8'h1C, 32'h1);
    rd_chk("R13 out word2", 8'h58, 32'h3333_3333);
    expect32("R9 cleared by output read", {31'd0, irq}, 32'd0);
    rd_chk("R9 status after read", 8'h1C, 32'h0);
    pulse_done();
    wr32(8'h14, 32'h1);
    expect32("R4 irq masked off", {31'd0, irq}, 32'd0);
    wr32(8'h00, 32'h1);
    @(negedge clk);
    rd_chk("R9 cleared by start", 8'h1C, 32'h0);
    wr32(8'h10, 32'h1);

    // policy 1
    wr32(8'h04, 32'h100);
    n0 = n_start;
    for (int i = 0; i < 3; i++) wr32(8'h40 + 8'(4*i), 32'hB0B0_0000 + i);
    expect32("R6 three words no start", n_start, n0);
    wr32(8'h4C, 32'hB0B0_0003);
    @(negedge clk);
    expect32("R6 fourth word starts", n_start, n0 + 1);
    wr32(8'h4C, 32'hB0B0_0013);
    @(negedge clk);
    expect32("R6 partial rewrite no start", n_start, n0 + 1);

    // policy 2, no double buffer
    wr32(8'h04, 32'h200);
    n0 = n_start;
    wr32(8'h44, 32'hC0C0_0001);
    @(negedge clk);
    expect32("R7 word1 no start", n_start, n0);
    wr32(8'h40, 32'hC0C0_0000);
    @(negedge clk);
    expect32("R7 word0 starts", n_start, n0 + 1);
    core_busy = 1'b1;
    wr32(8'h48, 32'h5555_5555);
    expect32("R8 dropped in policy 2", core_din[95:64], 32'hB0B0_0002);
    rd_chk("R8 code 0", 8'h1C, 32'h0000_0100);
    core_busy = 1'b0;

    // policy 2 with double buffer
    wr32(8'h04, 32'h208);
    core_busy = 1'b1;
    n0 = n_start;
    wr32(8'h40, 32'hD0D0_0000);
    expect32("R8 double buffer accepted", core_din[31:0], 32'hD0D0_0000);
    @(negedge clk);
    expect32("R7 held while busy", n_start, n0);
    core_busy = 1'b0;
    repeat (2) @(negedge clk);
    expect32("R7 pending start issued", n_start, n0 + 1);

    // soft reset aborts pending start
    core_busy = 1'b1;
    n0 = n_start;
    wr32(8'h40, 32'hE0E0_0000);
    wr32(8'h00, 32'h100);
    core_busy = 1'b0;
    repeat (3) @(negedge clk);
    expect32("R1 pending start dropped", n_start, n0);
    rd_chk("R1 mode cleared", 8'h04, 32'h0);
    rd_chk("R1 mask cleared", 8'h18, 32'h0);
    expect32("R1 key cleared", core_key[31:0], 32'h0);
    expect32("R1 din cleared", core_din[31:0], 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule